// File: doc/BRIEF.md
# Transponder Reply FSK Framer

This block turns a transponder's reply into a frequency-shift-keyed square wave. The square wave is derived from the system clock. When a send strobe arrives while the block is idle, it captures three inputs: a 24-bit serial number, a 24-bit signature and a secret 16-bit check seed. It then streams out a frame made of a run of zero bits for reader synchronisation, a fixed sync byte of 0x7E, the payload, and a 16-bit check word. The check word is computed on the fly. It is a bit-reflected CRC-CCITT whose register is preloaded with the secret seed rather than a fixed constant.

Each frame bit is carried by a fixed count of full carrier periods. The bit value selects the carrier frequency. A zero uses the shorter half-period, which gives the higher tone. A one uses the longer half-period. Every bit starts on a rising carrier edge and ends after a complete low half. This means a frequency change never cuts a carrier period short. The upstream logic raises the send strobe once the reader's command has been fully handled. It watches the busy flag to learn when the line is free again.

Top module: `fsk_reply_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o` is 0 and `carrier_o` is held at 0.
- R2: A `send_i` pulse seen at a clock edge while idle is accepted at that edge. From that edge on, `busy_o` is 1 and `carrier_o` is 1, which begins the first high half-period.
- R3: Each frame bit consists of exactly CYCLES_PER_BIT (default 16) carrier periods. Each period is high for H clocks and then low for H clocks. H is HALF_ZERO for a 0 bit and HALF_ONE for a 1 bit. The period length changes only where one bit ends and the next begins.
- R4: The frame opens with PREAMBLE_BITS bits of value 0.
- R5: The sync byte 0x7E follows the preamble and is sent least significant bit first.
- R6: The payload follows the sync byte. It is `serial_i` (bit 0 first) and then `sig_i` (bit 0 first), using the values captured at acceptance.
- R7: The check word is last and is sent bit 0 first, with no final inversion. It is computed over the 48 payload bits in the order they are sent. The register starts at the captured `crc_seed_i`. For each bit d, the feedback f is reg[0] XOR d; the register shifts right by one, and if f is 1 it is XORed with 0x8408.
- R8: `busy_o` stays 1 until the clock edge that completes the last check bit's final carrier period. At that edge `busy_o` and `carrier_o` both fall to 0.
- R9: While busy, a `send_i` pulse and any change on `serial_i`, `sig_i` or `crc_seed_i` have no effect on the frame in progress.
- R10: A `send_i` pulse at the first idle edge after a frame starts the next frame at once, with no dead cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Send strobe, acted on only while idle |
| serial_i | input | 24 | Serial number to transmit |
| sig_i | input | 24 | Signature to transmit |
| crc_seed_i | input | 16 | Secret start value of the check register |
| carrier_o | output | 1 | FSK square-wave output |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The bench builds the block with HALF_ZERO = 2, HALF_ONE = 3 and PREAMBLE_BITS = 5. A whole 77-bit frame then lasts a few thousand clocks, so a dozen frames fit easily in the run. The odd preamble length catches any logic that assumes a power-of-two field. Half-periods that differ by a single clock make every bit's value visible to a per-sample waveform compare. The seeded check word is tested with all-zero and all-one payloads, with extreme seeds, and with random data. Some frames also receive a strobe in the middle of the frame, together with changed input values.

// File: rtl/fsk_tx_pkg.sv
package fsk_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SYNC,
        PH_DATA,
        PH_CHK
    } phase_e;

    localparam int          CHK_W     = 16;
    localparam int          SYNC_W    = 8;
    localparam logic [7:0]  SYNC_BYTE = 8'h7E;
    localparam logic [15:0] CHK_POLY  = 16'h8408;

    // One step of the reflected check register for one input bit.
    function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] r, input logic d);
        logic fb;
        logic [CHK_W-1:0] s;
        fb = r[0] ^ d;
        s  = r >> 1;
        if (fb) s = s ^ CHK_POLY;
        return s;
    endfunction

endpackage

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
    import fsk_tx_pkg::*;
#(
    parameter int ID_W     = 24,
    parameter int SIG_W    = 24,
    parameter int PRE_BITS = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             send_i,
    input  logic [ID_W-1:0]  serial_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic [CHK_W-1:0] seed_i,
    input  logic             bit_done_i,
    output logic             start_o,
    output logic             busy_o,
    output logic             bit_o,
    output logic             last_o
);
    localparam int PAY_W  = ID_W + SIG_W;
    localparam int MAX_A  = (PAY_W > PRE_BITS) ? PAY_W : PRE_BITS;
    localparam int MAX_F  = (MAX_A > CHK_W) ? MAX_A : CHK_W;
    localparam int IDX_W  = $clog2(MAX_F + 1);

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        logic [PAY_W-1:0]   pay;
        logic [CHK_W-1:0]   chk;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d       = q;
        start_o = send_i && (q.phase == PH_IDLE);
        if (start_o) begin
            d.phase = PH_PRE;
            d.idx   = '0;
            d.pay   = {sig_i, serial_i};
            d.chk   = seed_i;
        end else if (bit_done_i) begin
            case (q.phase)
                PH_PRE: begin
                    if (q.idx == IDX_W'(PRE_BITS - 1)) begin
                        d.phase = PH_SYNC;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                PH_SYNC: begin
                    if (q.idx == IDX_W'(SYNC_W - 1)) begin
                        d.phase = PH_DATA;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                PH_DATA: begin
                    d.chk = chk_step(q.chk, q.pay[0]);
                    d.pay = q.pay >> 1;
                    if (q.idx == IDX_W'(PAY_W - 1)) begin
                        d.phase = PH_CHK;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                PH_CHK: begin
                    d.chk = q.chk >> 1;
                    if (q.idx == IDX_W'(CHK_W - 1)) begin
                        d.phase = PH_IDLE;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (q.phase)
            PH_SYNC: bit_o = SYNC_BYTE[q.idx[2:0]];
            PH_DATA: bit_o = q.pay[0];
            PH_CHK:  bit_o = q.chk[0];
            default: bit_o = 1'b0;
        endcase
        busy_o = (q.phase != PH_IDLE);
        last_o = (q.phase == PH_CHK) && (q.idx == IDX_W'(CHK_W - 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // The bit value may change only where one bit ends and the next begins.
    assert_bit_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !bit_done_i) |=> $stable(bit_o));

    // The first bit of every frame belongs to the zero preamble.
    assert_first_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> (busy_o && !bit_o));

    // A strobe arriving during a frame does not restart it or move it.
    assert_ignore_send_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && send_i && !bit_done_i) |=> ($stable(q.phase) && $stable(q.idx)));

endmodule

// File: rtl/fsk_carrier_gen.sv
module fsk_carrier_gen #(
    parameter int HALF_ZERO      = 60,
    parameter int HALF_ONE       = 65,
    parameter int CYCLES_PER_BIT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    input  logic bit_i,
    input  logic last_i,
    output logic carrier_o,
    output logic bit_done_o
);
    localparam int HMAX  = (HALF_ZERO > HALF_ONE) ? HALF_ZERO : HALF_ONE;
    localparam int CNT_W = $clog2(HMAX + 1);
    localparam int CYC_W = $clog2(CYCLES_PER_BIT + 1);

    typedef struct packed {
        logic             car;
        logic [CNT_W-1:0] cnt;
        logic [CYC_W-1:0] cyc;
    } car_s;

    car_s q, d;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim        = bit_i ? CNT_W'(HALF_ONE - 1) : CNT_W'(HALF_ZERO - 1);
        d          = q;
        bit_done_o = 1'b0;
        if (start_i) begin
            d.car = 1'b1;
            d.cnt = '0;
            d.cyc = '0;
        end else if (run_i) begin
            if (q.cnt == lim) begin
                d.cnt = '0;
                if (q.car) begin
                    d.car = 1'b0;
                end else if (q.cyc == CYC_W'(CYCLES_PER_BIT - 1)) begin
                    bit_done_o = 1'b1;
                    d.cyc      = '0;
                    d.car      = !last_i;
                end else begin
                    d.cyc = q.cyc + 1'b1;
                    d.car = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d = '0;
        end
    end

    assign carrier_o = q.car;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // The period counter never passes the number of periods in one bit.
    assert_cyc_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cyc < CYC_W'(CYCLES_PER_BIT));

    // A bit always closes at the end of a low half, so every period is whole.
    assert_whole_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_done_o && !last_i) |=> $rose(carrier_o));

endmodule

// File: rtl/fsk_reply_tx.sv
module fsk_reply_tx
    import fsk_tx_pkg::*;
#(
    parameter int ID_W           = 24,
    parameter int SIG_W          = 24,
    parameter int PREAMBLE_BITS  = 16,
    parameter int CYCLES_PER_BIT = 16,
    parameter int HALF_ZERO      = 60,
    parameter int HALF_ONE       = 65
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             send_i,
    input  logic [ID_W-1:0]  serial_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic [15:0]      crc_seed_i,
    output logic             carrier_o,
    output logic             busy_o
);
    logic start, bit_val, last_bit, bit_done;

    fsk_frame_seq #(
        .ID_W    (ID_W),
        .SIG_W   (SIG_W),
        .PRE_BITS(PREAMBLE_BITS)
    ) seq_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .send_i    (send_i),
        .serial_i  (serial_i),
        .sig_i     (sig_i),
        .seed_i    (crc_seed_i),
        .bit_done_i(bit_done),
        .start_o   (start),
        .busy_o    (busy_o),
        .bit_o     (bit_val),
        .last_o    (last_bit)
    );

    fsk_carrier_gen #(
        .HALF_ZERO     (HALF_ZERO),
        .HALF_ONE      (HALF_ONE),
        .CYCLES_PER_BIT(CYCLES_PER_BIT)
    ) car_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .run_i     (busy_o),
        .bit_i     (bit_val),
        .last_i    (last_bit),
        .carrier_o (carrier_o),
        .bit_done_o(bit_done)
    );

    // The output is quiet whenever no frame is in flight.
    assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !carrier_o);

    // An idle strobe starts a frame with the carrier high at once.
    assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && send_i) |=> (busy_o && carrier_o));

    // Busy drops only together with the end of the last check bit.
    assert_busy_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(last_bit && bit_done));

endmodule

// File: tb/fsk_reply_tx_tb_top.sv
module fsk_reply_tx_tb_top;
    localparam int PRE = 5;
    localparam int HZ  = 2;
    localparam int HO  = 3;
    localparam int CPB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send = 1'b0;
    logic [23:0] serial = '0, sig = '0;
    logic [15:0] seed = '0;
    logic carrier, busy;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic ebits [0:127];
    int nbits;

    always #2.5 clk = ~clk;

    fsk_reply_tx #(
        .PREAMBLE_BITS (PRE),
        .CYCLES_PER_BIT(CPB),
        .HALF_ZERO     (HZ),
        .HALF_ONE      (HO)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .send_i    (send),
        .serial_i  (serial),
        .sig_i     (sig),
        .crc_seed_i(seed),
        .carrier_o (carrier),
        .busy_o    (busy)
    );

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] model_chk(input logic [23:0] s, input logic [23:0] g, input logic [15:0] sd);
        logic [47:0] p;
        logic [15:0] c;
        logic f;
        p = {g, s};
        c = sd;
        for (int i = 0; i < 48; i++) begin
            f = c[0] ^ p[i];
            c = c >> 1;
            if (f) c = c ^ 16'h8408;
        end
        return c;
    endfunction

    task automatic build_frame(input logic [23:0] s, input logic [23:0] g, input logic [15:0] sd);
        logic [15:0] c;
        logic [7:0] sy;
        c = model_chk(s, g, sd);
        sy = 8'h7E;
        nbits = 0;
        for (int i = 0; i < PRE; i++) begin ebits[nbits] = 1'b0; nbits++; end
        for (int i = 0; i < 8; i++)   begin ebits[nbits] = sy[i]; nbits++; end
        for (int i = 0; i < 24; i++)  begin ebits[nbits] = s[i]; nbits++; end
        for (int i = 0; i < 24; i++)  begin ebits[nbits] = g[i]; nbits++; end
        for (int i = 0; i < 16; i++)  begin ebits[nbits] = c[i]; nbits++; end
    endtask

    // Called at a negedge; returns at a negedge where the frame is over.
    task automatic run_frame(input logic [23:0] s, input logic [23:0] g, input logic [15:0] sd,
                             input int inj, input bit b2b, input int fno);
        int smp, rises, hlen;
        int err [0:4];
        int efirst [0:4];
        logic egot [0:4];
        logic prev, ec;
        int fld;
        build_frame(s, g, sd);
        for (int k = 0; k < 5; k++) begin err[k] = 0; efirst[k] = -1; egot[k] = 1'b0; end
        serial = s; sig = g; seed = sd; send = 1'b1;
        smp = 0; rises = 0; prev = 1'b0;
        for (int b = 0; b < nbits; b++) begin
            hlen = ebits[b] ? HO : HZ;
            if (b < PRE) fld = 0;
            else if (b < PRE + 8) fld = 1;
            else if (b < PRE + 56) fld = 2;
            else fld = 3;
            for (int c = 0; c < CPB; c++) begin
                for (int h = 0; h < 2 * hlen; h++) begin
                    @(negedge clk);
                    if (smp == 0) begin
                        send = 1'b0;
                        check(busy && carrier, "R2 accept", {busy, carrier}, 2'b11);
                        if (b2b) check(busy && carrier, "R10 back-to-back start", {busy, carrier}, 2'b11);
                        serial = $urandom; sig = $urandom; seed = $urandom;
                    end
                    if (smp == inj) begin
                        send = 1'b1; serial = $urandom; sig = $urandom; seed = $urandom;
                    end else if (smp == inj + 1) begin
                        send = 1'b0;
                    end
                    ec = (h < hlen);
                    if (carrier !== ec) begin
                        if (efirst[fld] < 0) begin efirst[fld] = smp; egot[fld] = carrier; end
                        err[fld]++;
                    end
                    if (busy !== 1'b1) begin
                        if (efirst[4] < 0) efirst[4] = smp;
                        err[4]++;
                    end
                    if (carrier && !prev) rises++;
                    prev = carrier;
                    smp++;
                end
            end
        end
        check(err[0] == 0, $sformatf("R4 preamble frame %0d sample %0d", fno, efirst[0]), egot[0], !egot[0]);
        check(err[1] == 0, $sformatf("R5 sync byte frame %0d sample %0d", fno, efirst[1]), egot[1], !egot[1]);
        check(err[2] == 0, $sformatf("R6 payload frame %0d sample %0d", fno, efirst[2]), egot[2], !egot[2]);
        check(err[3] == 0, $sformatf("R7 check word frame %0d sample %0d", fno, efirst[3]), egot[3], !egot[3]);
        check(rises == nbits * CPB, $sformatf("R3 carrier periods frame %0d", fno), rises, nbits * CPB);
        check(err[4] == 0, $sformatf("R8 busy held frame %0d first drop %0d", fno, efirst[4]), err[4], 0);
        if (inj >= 0)
            check(err[0] + err[1] + err[2] + err[3] == 0, $sformatf("R9 mid-frame strobe frame %0d", fno),
                  err[0] + err[1] + err[2] + err[3], 0);
        @(negedge clk);
        check(!busy && !carrier, $sformatf("R8 frame end frame %0d", fno), {busy, carrier}, 2'b00);
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!busy && !carrier, "R1 idle output low", {busy, carrier}, 2'b00);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got=%0d exp<%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0F5C));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !carrier, "R1 reset state", {busy, carrier}, 2'b00);
        idle_gap(3);
        run_frame(24'h000000, 24'h000000, 16'h0000, -1, 1'b0, 0);
        run_frame(24'hFFFFFF, 24'hFFFFFF, 16'hFFFF, -1, 1'b1, 1);
        idle_gap(2);
        run_frame(24'h000001, 24'h800000, 16'h1D0F, 100, 1'b0, 2);
        run_frame(24'hA5A5A5, 24'h5A5A5A, 16'h8408, 3000, 1'b1, 3);
        for (int f = 4; f < 12; f++) begin
            int gap;
            gap = $urandom_range(0, 4);
            idle_gap(gap);
            run_frame($urandom, $urandom, $urandom, (f % 2 == 0) ? int'($urandom_range(1, 3500)) : -1,
                      (gap == 0), f);
        end
        idle_gap(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule